// File: doc/BRIEF.md
# Programmable Sample Delay Line Bank

This block holds a bank of independent sample delay lines. Each line stores every incoming sample in a circular register memory and returns, one register stage later, the sample that arrived a programmed number of sample periods earlier. The delay can be set from zero up to one less than the memory depth. A write position advances once for each valid input sample. The read position trails the write position by the active offset, and the subtraction wraps around the memory.

Each line has two offset registers. Software writes into a staging copy through a single configuration port, and it may do so at any time. The copy that sets the delay is loaded from the staging copy only when a chosen sync line pulses. Each lane has a select field that picks one of several sync inputs. A new delay therefore takes effect on a frame boundary and never in the middle of a frame. When several lines must change their delay together, they can share one sync source.

Top module: `dly_line_bank`

## Requirements
- R1: While reset is held low, `out_valid` is 0 and every lane of `out_data` is 0. Reset sets every lane's staged offset, active offset and sync select to 0. The memory contents are not cleared.
- R2: `out_valid` equals `in_valid` delayed by one clock. On a cycle with `in_valid` low, `out_data` keeps its previous value and the input data is ignored.
- R3: With active offset D > 0, after the k-th valid sample (counting from 0 since reset) a lane's `out_data` equals that lane's valid sample k-D. Both D and k are counted in valid samples only.
- R4: With active offset 0, a lane's `out_data` equals the lane's input sample of the previous valid cycle.
- R5: When D exceeds the number of valid samples written since reset, the lane outputs 0 in place of memory contents.
- R6: A write on the configuration port (`cfg_we` high, lane index `cfg_lane`) places `cfg_offset` in the lane's staged offset and `cfg_sync_sel` in its sync select. The delay in use does not change until a sync load.
- R7: A lane loads its active offset from its staged offset only in a cycle where `sync_in[sel]` is high. Here sel is the lane's sync select as it stood before that cycle. Pulses on other sync inputs are ignored.
- R8: If a configuration write to a lane and that lane's sync load fall in the same cycle, the active offset takes the newly written `cfg_offset`.
- R9: A sync load with no pending write keeps the same delay, and the output sequence continues without a break.
- R10: A configuration write or sync load on one lane leaves the delay of every other lane unchanged.
- R11: The largest offset, DEPTH-1 (63 by default), delays by exactly that many samples once the write position has wrapped around the memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A new sample is present on every lane |
| in_data | input | NLANE x WIDTH | Input samples, one word per lane |
| out_valid | output | 1 | Delayed samples are present |
| out_data | output | NLANE x WIDTH | Delayed samples, one word per lane |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_lane | input | clog2(NLANE) | Lane addressed by the write |
| cfg_offset | input | clog2(DEPTH) | Offset to stage |
| cfg_sync_sel | input | clog2(NSYNC) | Sync input that loads this lane's offset |
| sync_in | input | NSYNC | Sync event pulses |

## Verification
The assertions assume that each sync input is a single-cycle pulse sampled on the clock. They also assume that `cfg_lane` names an existing lane whenever `cfg_we` is high, and that no input is X after reset. The stimulus drives every input at the falling edge and always holds `cfg_lane` below the lane count. It deliberately applies sync pulses on non-selected inputs, on all inputs at once, and in the same cycle as a write. Data on idle cycles is garbage, which shows that the hold on idle cycles does not depend on the input staying still.

// File: rtl/dly_pkg.sv
package dly_pkg;

  localparam int unsigned DLY_DEPTH_DEF = 64;
  localparam int unsigned DLY_NSYNC_DEF = 8;

  // Where the next output word comes from
  typedef enum logic [1:0] {
    SRC_BYPASS = 2'd0,
    SRC_MEM    = 2'd1,
    SRC_MASK   = 2'd2
  } rd_src_e;

endpackage

// File: rtl/dly_store.sv
module dly_store
  import dly_pkg::*;
#(
  parameter int unsigned WIDTH = 16,
  parameter int unsigned DEPTH = DLY_DEPTH_DEF
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic [WIDTH-1:0]         in_data,
  input  logic [$clog2(DEPTH)-1:0] act_off,
  output logic                     out_valid,
  output logic [WIDTH-1:0]         out_data
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned FW = AW + 1;
  localparam logic [FW-1:0] FILL_MAX = FW'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr;
  logic [FW-1:0]    fill;
  rd_src_e          src;
  logic [WIDTH-1:0] rd_word;
  logic [WIDTH-1:0] nxt_word;

  // read position trails the write position, wrapping (DEPTH is a power of two)
  function automatic logic [AW-1:0] rd_addr(input logic [AW-1:0] w, input logic [AW-1:0] o);
    return w - o;
  endfunction

  // offset 0 bypasses; offsets beyond the written history are masked
  function automatic rd_src_e pick_src(input logic [AW-1:0] o, input logic [FW-1:0] f);
    if (o == '0)            return SRC_BYPASS;
    else if ({1'b0, o} <= f) return SRC_MEM;
    else                     return SRC_MASK;
  endfunction

  function automatic logic [FW-1:0] fill_next(input logic [FW-1:0] f);
    return (f == FILL_MAX) ? f : f + 1'b1;
  endfunction

  assign src     = pick_src(act_off, fill);
  assign rd_word = mem[rd_addr(wr_ptr, act_off)];

  always_comb begin
    unique case (src)
      SRC_BYPASS: nxt_word = in_data;
      SRC_MEM:    nxt_word = rd_word;
      default:    nxt_word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (in_valid) mem[wr_ptr] <= in_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr    <= '0;
      fill      <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        wr_ptr   <= wr_ptr + 1'b1;
        fill     <= fill_next(fill);
        out_data <= nxt_word;
      end
    end
  end

endmodule

// File: rtl/dly_offset_ctl.sv
module dly_offset_ctl #(
  parameter int unsigned AW    = 6,
  parameter int unsigned NSYNC = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_hit,
  input  logic [AW-1:0]             wr_offset,
  input  logic [$clog2(NSYNC)-1:0]  wr_sel,
  input  logic [NSYNC-1:0]          sync_in,
  output logic                      load,
  output logic [AW-1:0]             act_off
);
  localparam int unsigned SW = $clog2(NSYNC);

  logic [AW-1:0] shadow;
  logic [SW-1:0] sel_q;

  // a write in the loading cycle wins over the older staged value
  function automatic logic [AW-1:0] load_value(input logic hit, input logic [AW-1:0] w,
                                               input logic [AW-1:0] s);
    return hit ? w : s;
  endfunction

  assign load = sync_in[sel_q];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow  <= '0;
      sel_q   <= '0;
      act_off <= '0;
    end else begin
      if (wr_hit) begin
        shadow <= wr_offset;
        sel_q  <= wr_sel;
      end
      if (load) act_off <= load_value(wr_hit, wr_offset, shadow);
    end
  end

endmodule

// File: rtl/dly_lane.sv
module dly_lane
  import dly_pkg::*;
#(
  parameter int unsigned WIDTH = 16,
  parameter int unsigned DEPTH = DLY_DEPTH_DEF,
  parameter int unsigned NSYNC = DLY_NSYNC_DEF
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic [WIDTH-1:0]         in_data,
  input  logic                     wr_hit,
  input  logic [$clog2(DEPTH)-1:0] wr_offset,
  input  logic [$clog2(NSYNC)-1:0] wr_sel,
  input  logic [NSYNC-1:0]         sync_in,
  output logic                     load,
  output logic [$clog2(DEPTH)-1:0] act_off,
  output logic                     out_valid,
  output logic [WIDTH-1:0]         out_data
);
  localparam int unsigned AW = $clog2(DEPTH);

  dly_offset_ctl #(.AW(AW), .NSYNC(NSYNC)) u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_hit    (wr_hit),
    .wr_offset (wr_offset),
    .wr_sel    (wr_sel),
    .sync_in   (sync_in),
    .load      (load),
    .act_off   (act_off)
  );

  dly_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .act_off   (act_off),
    .out_valid (out_valid),
    .out_data  (out_data)
  );

endmodule

// File: rtl/dly_line_bank.sv
module dly_line_bank
  import dly_pkg::*;
#(
  parameter int unsigned NLANE = 4,
  parameter int unsigned WIDTH = 16,
  parameter int unsigned DEPTH = DLY_DEPTH_DEF,
  parameter int unsigned NSYNC = DLY_NSYNC_DEF
) (
  input  logic                                        clk,
  input  logic                                        rst_n,
  input  logic                                        in_valid,
  input  logic [NLANE-1:0][WIDTH-1:0]                 in_data,
  output logic                                        out_valid,
  output logic [NLANE-1:0][WIDTH-1:0]                 out_data,
  input  logic                                        cfg_we,
  input  logic [((NLANE > 1) ? $clog2(NLANE) : 1)-1:0] cfg_lane,
  input  logic [$clog2(DEPTH)-1:0]                    cfg_offset,
  input  logic [$clog2(NSYNC)-1:0]                    cfg_sync_sel,
  input  logic [NSYNC-1:0]                            sync_in
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned LW = (NLANE > 1) ? $clog2(NLANE) : 1;

  // internal events brought out for the checker
  logic [NLANE-1:0]          lane_load;
  logic [NLANE-1:0]          lane_hit;
  logic [NLANE-1:0][AW-1:0]  act_off;
  logic [NLANE-1:0]          lane_vld;

  assign out_valid = lane_vld[0];

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    assign lane_hit[g] = cfg_we && (cfg_lane == LW'(g));

    dly_lane #(.WIDTH(WIDTH), .DEPTH(DEPTH), .NSYNC(NSYNC)) u_lane (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_data   (in_data[g]),
      .wr_hit    (lane_hit[g]),
      .wr_offset (cfg_offset),
      .wr_sel    (cfg_sync_sel),
      .sync_in   (sync_in),
      .load      (lane_load[g]),
      .act_off   (act_off[g]),
      .out_valid (lane_vld[g]),
      .out_data  (out_data[g])
    );
  end

endmodule

// File: rtl/dly_line_bank_chk.sv
module dly_line_bank_chk #(
  parameter int unsigned NLANE = 4,
  parameter int unsigned WIDTH = 16,
  parameter int unsigned AW    = 6,
  parameter int unsigned LW    = 2
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       in_valid,
  input logic [NLANE-1:0][WIDTH-1:0] in_data,
  input logic                       out_valid,
  input logic [NLANE-1:0][WIDTH-1:0] out_data,
  input logic                       cfg_we,
  input logic [LW-1:0]              cfg_lane,
  input logic [AW-1:0]              cfg_offset,
  input logic [NLANE-1:0]           lane_load,
  input logic [NLANE-1:0][AW-1:0]   act_off
);

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R2
  AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R2
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_data)); // R2

  for (genvar g = 0; g < NLANE; g++) begin : g_chk
    AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      !lane_load[g] |=> $stable(act_off[g])); // R7
    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (lane_load[g] && cfg_we && cfg_lane == LW'(g)) |=> act_off[g] == $past(cfg_offset)); // R8
    AST_ZERO_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && act_off[g] == '0) |=> out_data[g] == $past(in_data[g])); // R4
  end

endmodule

bind dly_line_bank dly_line_bank_chk #(
  .NLANE (NLANE),
  .WIDTH (WIDTH),
  .AW    (AW),
  .LW    (LW)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_data    (in_data),
  .out_valid  (out_valid),
  .out_data   (out_data),
  .cfg_we     (cfg_we),
  .cfg_lane   (cfg_lane),
  .cfg_offset (cfg_offset),
  .lane_load  (lane_load),
  .act_off    (act_off)
);

// File: tb/sim_dly_line_bank.sv
module sim_dly_line_bank;
  localparam int NL = 4;
  localparam int W  = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [NL-1:0][W-1:0] in_data = '0;
  logic out_valid;
  logic [NL-1:0][W-1:0] out_data;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_lane = '0;
  logic [5:0] cfg_offset = '0;
  logic [2:0] cfg_sync_sel = '0;
  logic [7:0] sync_in = '0;

  always #10 clk = ~clk; // 50 MHz

  dly_line_bank u0 (
    .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .in_data (in_data),
    .out_valid (out_valid), .out_data (out_data), .cfg_we (cfg_we),
    .cfg_lane (cfg_lane), .cfg_offset (cfg_offset), .cfg_sync_sel (cfg_sync_sel),
    .sync_in (sync_in)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  // bench model
  int idx;
  int m_act  [NL];
  int m_shad [NL];
  int m_sel  [NL];
  logic [W-1:0] last_exp [NL];

  // lane, offset, sync select
  localparam logic [10:0] VEC [6] = '{
    {2'd0, 6'd5,  3'd2},
    {2'd1, 6'd63, 3'd7},
    {2'd2, 6'd1,  3'd0},
    {2'd3, 6'd32, 3'd5},
    {2'd0, 6'd0,  3'd4},
    {2'd2, 6'd17, 3'd3}
  };

  function automatic logic [W-1:0] smp(input int l, input int i);
    return W'((l * 16'h1111) ^ (i * 16'h0137 + 1));
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    idx = 0;
    for (int l = 0; l < NL; l++) begin
      m_act[l] = 0; m_shad[l] = 0; m_sel[l] = 0; last_exp[l] = '0;
    end
  endtask

  task automatic cycle(input bit v, input bit we, input int wl, input int wo, input int ws,
                       input logic [7:0] sy, input string tag);
    string t;
    @(negedge clk);
    in_valid = v;
    for (int l = 0; l < NL; l++) in_data[l] = v ? smp(l, idx) : W'(16'hDEAD + l);
    cfg_we = we; cfg_lane = 2'(wl); cfg_offset = 6'(wo); cfg_sync_sel = 3'(ws);
    sync_in = sy;
    @(posedge clk);
    #2;
    chk(out_valid == v, "R2", int'(out_valid), int'(v));
    for (int l = 0; l < NL; l++) begin
      t = tag;
      if (v) begin
        if (m_act[l] == 0) t = "R4";
        else if (idx < m_act[l]) t = "R5";
        last_exp[l] = (idx >= m_act[l]) ? smp(l, idx - m_act[l]) : '0;
      end else t = "R2";
      chk(out_data[l] == last_exp[l], t, int'(out_data[l]), int'(last_exp[l]));
    end
    if (v) idx++;
    for (int l = 0; l < NL; l++)
      if (sy[m_sel[l]]) m_act[l] = (we && wl == l) ? wo : m_shad[l];
    if (we) begin m_shad[wl] = wo; m_sel[wl] = ws; end
  endtask

  task automatic stream(input int n, input string tag);
    for (int k = 0; k < n; k++) cycle(1, 0, 0, 0, 0, 8'h00, tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; in_valid = 0; cfg_we = 0; sync_in = '0;
    repeat (3) @(posedge clk);
    #2;
    chk(out_valid == 1'b0, "R1", int'(out_valid), 0);
    for (int l = 0; l < NL; l++) chk(out_data[l] == '0, "R1", int'(out_data[l]), 0);
    model_reset();
    @(negedge clk);
    rst_n = 1;
  endtask

  initial begin
    #(20 * 200000);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    end
    $finish;
  end

  initial begin
    model_reset();
    do_reset();
    // R1: offsets are 0 after reset, so every lane passes through
    stream(10, "R1");
    cycle(0, 0, 0, 0, 0, 8'h00, "R2");
    stream(2, "R2");

    // table walk: stage, verify unchanged (R6), load by selected sync (R7), stream (R3)
    for (int v = 0; v < 6; v++) begin
      int ln, of, sl;
      ln = int'(VEC[v][10:9]); of = int'(VEC[v][8:3]); sl = int'(VEC[v][2:0]);
      cycle(1, 1, ln, of, sl, 8'h00, "R6");
      stream(3, "R6");
      cycle(1, 0, 0, 0, 0, 8'(1 << sl), "R7");
      stream(70, (of == 63) ? "R11" : "R3");
      cycle(0, 0, 0, 0, 0, 8'h00, "R2");
    end

    // R7: pulses on every non-selected line leave lane 3 unchanged
    cycle(1, 1, 3, 9, 1, 8'h00, "R6");
    cycle(1, 0, 0, 0, 0, 8'hFD, "R7");
    stream(40, "R10");
    cycle(1, 0, 0, 0, 0, 8'h02, "R7");
    stream(20, "R7");

    // R8: write and load in the same cycle (lane 0 select is still 4)
    cycle(1, 1, 0, 12, 6, 8'h10, "R8");
    stream(20, "R8");

    // R9: reload with nothing pending on every lane
    cycle(1, 0, 0, 0, 0, 8'hFF, "R9");
    stream(20, "R9");

    // R5: reset keeps old memory; masking must hide it
    do_reset();
    cycle(0, 1, 2, 10, 0, 8'h01, "R8");
    stream(20, "R5");
    cycle(1, 1, 1, 63, 0, 8'h01, "R8");
    stream(140, "R11");

    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    end
    $finish;
  end

endmodule